// File: doc/BRIEF.md
# Multi-Mode Timer Counter

A 32-bit up-counter steered by a small register port. Software picks the count source: either a divide-by-16 internal prescaler, or edges of an external clock pin. The external pin is brought into the system clock domain and counted on the chosen edge. A two-bit mode field selects interval operation or watchdog operation. In interval mode the counter wraps at a programmable compare value and emits a one-cycle interrupt pulse. In watchdog mode it raises a sticky expiry flag.

Stopping the counter follows one rule. When software writes the run bit from 1 to 0, the clear-enable bit is looked at once, and the counter and prescaler go to zero only if that bit is set. The clear-enable value used is the one carried by the same write. In watchdog mode, clearing the run bit does not halt counting. Only a separate disable bit can halt it.

The register port has a 2-bit address. Address 0 is control, 1 is compare, 2 is watchdog disable (bit 0), and 3 reads the count (read-only). Reads are combinational. Writes take effect on the clock edge where `reg_we` is high.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every control field, the compare value, the disable bit and the count read 0, and `irq_match` and `wdt_expired` are low.
- R2: The control word at address 0 holds run in bit 0, divider enable in bit 1, clear-enable in bit 2, rising-edge select in bit 3, external-source select in bit 4 and the mode in bits 6:5. All higher bits read 0 whatever was written.
- R3: With the internal source selected and the divider enabled, the count advances once every 16 cycles while running. With the divider disabled, it never advances.
- R4: With bit 4 set, the count advances once per synchronized edge of `ext_clk`: on rising edges when bit 3 is 1 and on falling edges when bit 3 is 0.
- R5: In interval mode (mode 00), a count step taken while the count equals the compare value sets the count to 0 and pulses `irq_match` high for exactly one cycle.
- R6: A write that moves run from 1 to 0 and carries clear-enable = 1 clears the count and the prescaler. On that edge the clear takes priority over a count step, so no interrupt is raised.
- R7: A run 1→0 write whose clear-enable is 0 leaves the count held. Setting clear-enable while run stays 1 has no effect on the count.
- R8: Modes 01 and 11 never advance the count.
- R9: In watchdog mode (mode 10), writing run = 0 makes the run bit read 0, but counting continues.
- R10: In watchdog mode, a count step at the compare value sets `wdt_expired`, which stays high until the disable bit is written 1. A disable bit of 1 also stops the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 compare, 2 disable, 3 count) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq_match | output | 1 | One-cycle pulse on interval wrap |
| wdt_expired | output | 1 | Sticky watchdog expiry |

## Verification
The stop-with-clear write and a prescaler count step can land on the same edge. Because a count step at the compare value also wraps and raises the interrupt, this coincidence decides whether the interrupt is raised. It is provoked by setting the compare value to 0 and placing the stop write exactly on the sixteenth running cycle, where the prescaler step falls due. A twin vector without clear-enable on that same edge must show the wrap and one interrupt. The cleared version must show a zero count and no interrupt, so the priority is judged from the difference between the pair.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_INTV  = 2'b00,
    MODE_PULSE = 2'b01,
    MODE_WDOG  = 2'b10,
    MODE_RSVD  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e mode;      // bits 6:5
    logic      src_ext;   // bit 4
    logic      edge_rise; // bit 3
    logic      clr_en;    // bit 2
    logic      div_en;    // bit 1
    logic      run;       // bit 0
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_WDIS = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr_i)     pre_d = '0;
    else if (en_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = en_i && (pre_q == {PRE_W{1'b1}});

  // R3: a prescaler step never lasts two cycles
  assert_pre_single_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic rise_sel_i,
  output logic tick_o
);
  logic [2:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[1:0], ext_i};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  logic rose, fell;
  assign rose   = sync_q[1] && !sync_q[2];
  assign fell   = !sync_q[1] && sync_q[2];
  assign tick_o = rise_sel_i ? rose : fell;

  // R4: one count step per detected edge
  assert_one_per_edge_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cnt_en_i,
  input  tmr_mode_e     mode_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          wdis_i,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o,
  output logic          wdt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;
  logic          wdt_q, wdt_d;
  logic          hit, step;

  assign hit  = (cnt_q == cmp_i);
  assign step = cnt_en_i && !clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (cnt_en_i) cnt_d = hit ? '0 : cnt_q + 1'b1;

    irq_d = step && hit && (mode_i == MODE_INTV);

    wdt_d = wdt_q;
    if (wdis_i)                                 wdt_d = 1'b0;
    else if (step && hit && mode_i == MODE_WDOG) wdt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      wdt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      wdt_q <= wdt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
  assign wdt_o = wdt_q;

  // R5: the interrupt is a single-cycle pulse and coincides with a wrapped count
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  assert_irq_wrap_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_q |-> (cnt_q == '0));
  // R10: expiry is sticky until disable
  assert_wdt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (wdt_q && !wdis_i) |=> wdt_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int CW    = 32,
  parameter int PRE_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          ext_clk,
  output logic          irq_match,
  output logic          wdt_expired
);
  localparam int PAD_W = CW - CTRL_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // register file
  tmr_ctrl_t     ctrl_q, ctrl_d, ctrl_wr;
  logic [CW-1:0] cmp_q, cmp_d;
  logic          wdis_q, wdis_d;
  logic          armed_q, armed_d;
  logic          wr_ctrl, stop_clr;

  assign ctrl_wr  = tmr_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign wr_ctrl  = reg_we && (reg_addr == ADDR_CTRL);
  // clear-enable is taken from the same write that drops run
  assign stop_clr = wr_ctrl && ctrl_q.run && !ctrl_wr.run && ctrl_wr.clr_en;

  always_comb begin
    ctrl_d  = ctrl_q;
    cmp_d   = cmp_q;
    wdis_d  = wdis_q;
    armed_d = armed_q;
    if (wr_ctrl) ctrl_d = ctrl_wr;
    if (reg_we && reg_addr == ADDR_CMP)  cmp_d  = reg_wdata;
    if (reg_we && reg_addr == ADDR_WDIS) wdis_d = reg_wdata[0];
    if (wdis_q)
      armed_d = 1'b0;
    else if (wr_ctrl && ctrl_wr.run && ctrl_wr.mode == MODE_WDOG)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cmp_q   <= '0;
      wdis_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmp_q   <= cmp_d;
      wdis_q  <= wdis_d;
      armed_q <= armed_d;
    end
  end

  // run qualification per mode
  logic active;
  always_comb begin
    unique case (ctrl_q.mode)
      MODE_INTV: active = ctrl_q.run;
      MODE_WDOG: active = armed_q && !wdis_q;
      default:   active = 1'b0;
    endcase
  end

  logic pre_en, pre_tick, ext_tick, count_en;
  assign pre_en   = active && !ctrl_q.src_ext && ctrl_q.div_en;
  assign count_en = active && (ctrl_q.src_ext ? ext_tick : pre_tick);

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en_i   (pre_en),
    .clr_i  (stop_clr),
    .tick_o (pre_tick)
  );

  tmr_edge_sync u_sync (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .ext_i      (ext_clk),
    .rise_sel_i (ctrl_q.edge_rise),
    .tick_o     (ext_tick)
  );

  logic [CW-1:0] cnt_w;
  tmr_count_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .clr_i    (stop_clr),
    .cnt_en_i (count_en),
    .mode_i   (ctrl_q.mode),
    .cmp_i    (cmp_q),
    .wdis_i   (wdis_q),
    .cnt_o    (cnt_w),
    .irq_o    (irq_match),
    .wdt_o    (wdt_expired)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
      ADDR_CMP:  reg_rdata = cmp_q;
      ADDR_WDIS: reg_rdata = {{(CW-1){1'b0}}, wdis_q};
      default:   reg_rdata = cnt_w;
    endcase
  end

  // R6: a stop write with clear-enable leaves a zero count
  assert_stop_clear_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_clr |=> (cnt_w == '0));
  // R7: without a step or a clear the count holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!count_en && !stop_clr) |=> $stable(cnt_w));
  // R8: unsupported modes never count
  assert_no_count_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ctrl_q.mode == MODE_PULSE || ctrl_q.mode == MODE_RSVD) && !stop_clr)
      |=> $stable(cnt_w));
endmodule

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ext_clk;
  logic        irq_match;
  logic        wdt_expired;

  int nchecks = 0;
  int nerr    = 0;
  int irq_seen = 0;
  bit timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq_match) irq_seen++;

  tmr_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .irq_match(irq_match), .wdt_expired(wdt_expired)
  );

  // internal source vectors: start, run n cycles, stop (clear per clr)
  typedef struct packed {
    logic [31:0] cmp;
    logic        div;
    logic [1:0]  mode;
    logic        clr;
    logic [15:0] n;
    logic [31:0] exp_cnt;
    logic [31:0] exp_irq;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'd100, 1'b1, 2'b00, 1'b0, 16'd79,  32'd5, 32'd0}, // R3 five steps
    '{32'd2,   1'b1, 2'b00, 1'b0, 16'd111, 32'd1, 32'd2}, // R5 wraps
    '{32'd0,   1'b1, 2'b00, 1'b0, 16'd15,  32'd0, 32'd1}, // R5 step on stop edge
    '{32'd0,   1'b1, 2'b00, 1'b1, 16'd15,  32'd0, 32'd0}, // R6 clear beats step
    '{32'd100, 1'b0, 2'b00, 1'b0, 16'd63,  32'd0, 32'd0}, // R3 divider off
    '{32'd100, 1'b1, 2'b01, 1'b0, 16'd63,  32'd0, 32'd0}, // R8 mode 01
    '{32'd100, 1'b1, 2'b11, 1'b0, 16'd63,  32'd0, 32'd0}, // R8 mode 11
    '{32'd100, 1'b1, 2'b00, 1'b1, 16'd70,  32'd0, 32'd0}, // R6 clear on stop
    '{32'd1,   1'b1, 2'b00, 1'b0, 16'd47,  32'd1, 32'd1}  // R5 compare 1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; ext_clk = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic ext_pulse;
    ext_clk = 1'b1; idle(4);
    ext_clk = 1'b0; idle(4);
  endtask

  task automatic run_all;
    logic [31:0] d;
    int base;

    // R1 reset state
    do_reset;
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(2'd1, d); chk("R1 cmp", d, 32'h0);
    rd(2'd2, d); chk("R1 wdis", d, 32'h0);
    rd(2'd3, d); chk("R1 count", d, 32'h0);
    chk("R1 irq", {31'b0, irq_match}, 32'h0);
    chk("R1 wdt", {31'b0, wdt_expired}, 32'h0);

    // R2 field layout, upper bits read 0
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 ctrl readback", d, 32'h0000_007F);
    wr(2'd0, 32'h0000_0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_reset;
      wr(2'd1, VEC[i].cmp);
      base = irq_seen;
      wr(2'd0, {25'b0, VEC[i].mode, 3'b000, VEC[i].div, 1'b1});
      idle(int'(VEC[i].n));
      wr(2'd0, {25'b0, VEC[i].mode, 2'b00, VEC[i].clr, VEC[i].div, 1'b0});
      idle(3);
      rd(2'd3, d);
      chk($sformatf("R3/R5/R6/R8 vec%0d count", i), d, VEC[i].exp_cnt);
      chk($sformatf("R5/R6 vec%0d irq pulses", i), irq_seen - base, VEC[i].exp_irq);
    end

    // R7 stop without clear holds
    do_reset;
    wr(2'd1, 32'd1000);
    wr(2'd0, 32'h3);
    idle(40);
    wr(2'd0, 32'h2);
    rd(2'd3, d); chk("R7 held after stop", d, 32'd2);
    idle(50);
    rd(2'd3, d); chk("R7 still held", d, 32'd2);

    // R7 clear-enable while running is ignored; new clr value (0) used on stop
    do_reset;
    wr(2'd1, 32'd1000);
    wr(2'd0, 32'h3);
    idle(35);
    wr(2'd0, 32'h7);
    idle(20);
    rd(2'd3, d); chk("R7 clr_en while running", d, 32'd3);
    wr(2'd0, 32'h2);
    idle(3);
    rd(2'd3, d); chk("R6 stop uses written clr_en=0", d, 32'd3);

    // R9/R10 watchdog
    do_reset;
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h43);
    idle(19);
    wr(2'd0, 32'h42);
    rd(2'd0, d); chk("R9 run bit reads 0", d, 32'h42);
    idle(29);
    rd(2'd3, d); chk("R9 keeps counting", d, 32'd3);
    chk("R10 not yet expired", {31'b0, wdt_expired}, 32'h0);
    idle(15);
    chk("R10 expired", {31'b0, wdt_expired}, 32'h1);
    chk("R10 no interval irq", {31'b0, irq_match}, 32'h0);
    idle(20);
    chk("R10 expiry sticky", {31'b0, wdt_expired}, 32'h1);
    wr(2'd2, 32'h1);
    idle(2);
    chk("R10 disable clears expiry", {31'b0, wdt_expired}, 32'h0);
    rd(2'd3, d); base = int'(d);
    idle(40);
    rd(2'd3, d); chk("R10 disable stops count", d, base);

    // R4 external source, rising then falling
    do_reset;
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h19);
    ext_pulse; ext_pulse; ext_pulse;
    ext_clk = 1'b1;
    idle(10);
    rd(2'd3, d); chk("R4 rising edges", d, 32'd4);
    wr(2'd0, 32'h04);
    idle(2);
    rd(2'd3, d); chk("R6 clear after external run", d, 32'd0);
    wr(2'd0, 32'h11);
    idle(4);
    ext_clk = 1'b0; idle(4);
    ext_pulse; ext_pulse;
    idle(10);
    rd(2'd3, d); chk("R4 falling edges", d, 32'd3);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; ext_clk = 1'b0;
    @(negedge clk);
    fork
      run_all;
      begin
        repeat (LIMIT) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule